// File: doc/BRIEF.md
# Two-Layer Spiking Neuron Array

This block is a feed-forward pair of leaky integrate-and-fire neuron layers. The input layer and the output layer each hold a parameterised number of neurons (16 by default), and every input neuron is wired to every output neuron. An incoming spike event carries three things: the index of the input neuron it targets, a signed synaptic weight, and a one-cycle valid strobe. The targeted input neuron adds the weight to its membrane potential. If the potential then exceeds that neuron's threshold, the neuron fires.

The two layers run as a two-stage pipeline. The event index is registered, and one cycle later it picks two things: which input neuron's firing is forwarded, and which column of the weight matrix feeds the output layer. Because the index does this steering, the array holds no connectivity table. A shared decay strobe halves every membrane potential in both layers. Thresholds and the full weight matrix arrive as flat configuration buses. The only results are the one-cycle spike pulses of the output layer.

Top module: `spike_mesh_layer`

## Requirements
- R1: A synchronous active-high `rst` sets all membrane potentials to 0, clears both layers' firing flags and the registered event index, and holds `spike_out` at 0.
- R2: An input neuron integrates only when `spike_vld` is high and `spike_src` equals its index; when `spike_vld` is low the weight and index have no effect on any neuron.
- R3: Membrane potentials are PW-bit two's complement values. A sum above the largest value saturates to it, and a sum below the smallest value saturates to it; they never wrap.
- R4: A neuron fires only in a cycle in which it receives a spike, and only when its updated potential is strictly greater than its threshold. Firing resets its potential to 0. Input neuron i's threshold is `thr_in[i*PW +: PW]`.
- R5: An input spike applied in the cycle before clock edge E1 causes any resulting output spikes to appear on `spike_out` right after edge E2, two edges later.
- R6: When input neuron i fires, output neuron j adds the weight `wt_mat[(i*N_OUT+j)*WW +: WW]`. Output neuron j compares against `thr_out[j*PW +: PW]` and drives `spike_out[j]`.
- R7: When `decay` is high, every neuron in both layers arithmetically shifts its potential right by one bit. When a spike arrives in the same cycle, the halving happens before the weight is added.
- R8: A new input spike may be applied every cycle. Stage two of one spike and stage one of the next run together without interfering.
- R9: Each output spike is a single-cycle pulse unless that output neuron fires again on the next forwarded spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spike_vld | input | 1 | One-cycle strobe marking an input spike event |
| spike_src | input | IW = clog2(N_IN) | Index of the targeted input neuron |
| spike_wt | input | WW | Signed weight applied to the targeted input neuron |
| decay | input | 1 | Global leak strobe: halves all potentials |
| thr_in | input | N_IN*PW | Signed thresholds of the input layer, neuron i at bits i*PW |
| thr_out | input | N_OUT*PW | Signed thresholds of the output layer, neuron j at bits j*PW |
| wt_mat | input | N_IN*N_OUT*WW | Signed weights, pair (i,j) at bits (i*N_OUT+j)*WW |
| spike_out | output | N_OUT | Output-layer spike pulses |

## Verification
The bench instantiates the array with 16 input and 16 output neurons, 8-bit weights and a narrowed 10-bit potential. With a 10-bit potential, five spikes at maximum weight drive a neuron into either saturation bound. The bench can then show clamping against the wrap-around alternative within a few cycles. A hand-chosen weight pattern gives each output neuron a strong self weight, a positive neighbour weight and a negative second-neighbour weight, so accumulation across several forwarded spikes, threshold equality and back-to-back pipelining all show up at the output pulses.

// File: rtl/spike_mesh_layer.sv
module spike_mesh_layer #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 16,
  parameter int WW    = 8,
  parameter int PW    = 16,
  localparam int IW   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        spike_vld,
  input  logic [IW-1:0]               spike_src,
  input  logic signed [WW-1:0]        spike_wt,
  input  logic                        decay,
  input  logic [N_IN*PW-1:0]          thr_in,
  input  logic [N_OUT*PW-1:0]         thr_out,
  input  logic [N_IN*N_OUT*WW-1:0]    wt_mat,
  output logic [N_OUT-1:0]            spike_out
);

  localparam logic signed [PW-1:0] P_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic signed [PW-1:0] P_MIN = {1'b1, {(PW-1){1'b0}}};
  localparam logic [N_IN-1:0]      ONE   = {{(N_IN-1){1'b0}}, 1'b1};

  function automatic logic signed [PW-1:0] integrate(
    input logic signed [PW-1:0] pot,
    input logic                 dec,
    input logic                 hit,
    input logic signed [WW-1:0] w
  );
    logic signed [PW-1:0] base;
    logic signed [PW:0]   sum;
    base = dec ? (pot >>> 1) : pot;
    sum  = {base[PW-1], base} + (hit ? {{(PW+1-WW){w[WW-1]}}, w} : {(PW+1){1'b0}});
    if (sum[PW] != sum[PW-1]) integrate = sum[PW] ? P_MIN : P_MAX;
    else                      integrate = sum[PW-1:0];
  endfunction

  logic [N_IN-1:0] hit_in;
  logic [N_IN-1:0] in_fire;
  logic [IW-1:0]   src_q;
  logic            fwd;

  assign hit_in = spike_vld ? (ONE << spike_src) : '0;
  assign fwd    = ({1'b0, src_q} < (IW+1)'(N_IN)) && in_fire[src_q];

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= spike_src;
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic signed [PW-1:0] pot, nxt;
    logic                 trip, fire_r;

    assign nxt  = integrate(pot, decay, hit_in[i], spike_wt);
    assign trip = hit_in[i] && (nxt > $signed(thr_in[i*PW +: PW]));
    assign in_fire[i] = fire_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pot    <= '0;
        fire_r <= 1'b0;
      end else begin
        fire_r <= trip;
        pot    <= trip ? '0 : nxt;
      end
    end

    // R4
    in_fire_clr_chk: assert property (@(posedge clk) disable iff (rst)
      fire_r |-> (pot == '0));
    // R2
    in_fire_src_chk: assert property (@(posedge clk) disable iff (rst)
      fire_r |-> ($past(spike_vld) && ($past(spike_src) == IW'(i))));
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic signed [WW-1:0] wsel;
    logic signed [PW-1:0] pot, nxt;
    logic                 trip, fire_r;

    assign wsel = wt_mat[(int'(src_q)*N_OUT + j)*WW +: WW];
    assign nxt  = integrate(pot, decay, fwd, wsel);
    assign trip = fwd && (nxt > $signed(thr_out[j*PW +: PW]));
    assign spike_out[j] = fire_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pot    <= '0;
        fire_r <= 1'b0;
      end else begin
        fire_r <= trip;
        pot    <= trip ? '0 : nxt;
      end
    end

    // R4
    out_fire_clr_chk: assert property (@(posedge clk) disable iff (rst)
      fire_r |-> (pot == '0));
  end

  // R2
  in_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_fire));

  // R5
  out_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|spike_out) |-> $past(|in_fire));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((spike_out == '0) && (in_fire == '0)));

endmodule

// File: tb/test_spike_mesh_layer.sv
`timescale 1ns/1ps
module test_spike_mesh_layer;
  localparam int N_IN = 16, N_OUT = 16, WW = 8, PW = 10, IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spike_vld = 1'b0;
  logic [IW-1:0] spike_src = '0;
  logic signed [WW-1:0] spike_wt = '0;
  logic decay = 1'b0;
  logic [N_IN*PW-1:0] thr_in;
  logic [N_OUT*PW-1:0] thr_out;
  logic [N_IN*N_OUT*WW-1:0] wt_mat;
  logic [N_OUT-1:0] spike_out;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spike_mesh_layer #(.N_IN(N_IN), .N_OUT(N_OUT), .WW(WW), .PW(PW)) i_spike_mesh_layer (
    .clk(clk), .rst(rst), .spike_vld(spike_vld), .spike_src(spike_src),
    .spike_wt(spike_wt), .decay(decay), .thr_in(thr_in), .thr_out(thr_out),
    .wt_mat(wt_mat), .spike_out(spike_out));

  // vld(1) src(4) wt(8) expected spike_out(16)
  localparam logic [28:0] VEC [0:11] = '{
    {1'b1, 4'd3,  8'h0A, 16'h0000},
    {1'b1, 4'd3,  8'h0F, 16'h0008},
    {1'b1, 4'd4,  8'h15, 16'h0010},
    {1'b1, 4'd3,  8'h15, 16'h0008},
    {1'b1, 4'd15, 8'h1E, 16'h8000},
    {1'b1, 4'd15, 8'h15, 16'h8001},
    {1'b1, 4'd5,  8'hFB, 16'h0000},
    {1'b1, 4'd5,  8'h19, 16'h0000},
    {1'b1, 4'd5,  8'h01, 16'h0000},
    {1'b1, 4'd5,  8'h15, 16'h0020},
    {1'b0, 4'd6,  8'h64, 16'h0000},
    {1'b1, 4'd6,  8'h05, 16'h0000}
  };

  task automatic chk(input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: spike_out=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_thr_in(input int i, input int v);
    thr_in[i*PW +: PW] = PW'(v);
  endtask

  task automatic set_thr_out(input int j, input int v);
    thr_out[j*PW +: PW] = PW'(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; spike_vld = 1'b0; decay = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(spike_out, '0, "R1 reset state");
  endtask

  task automatic apply(input logic vld, input int src, input int wt, input logic dec,
                       input logic [N_OUT-1:0] exp, input string tag);
    @(negedge clk);
    spike_vld = vld; spike_src = IW'(src); spike_wt = WW'(wt); decay = dec;
    @(negedge clk);
    spike_vld = 1'b0; decay = 1'b0; spike_wt = '0;
    @(negedge clk);
    chk(spike_out, exp, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_IN; i++) set_thr_in(i, 20);
    for (int j = 0; j < N_OUT; j++) set_thr_out(j, 30);
    wt_mat = '0;
    for (int i = 0; i < N_IN; i++) begin
      wt_mat[(i*N_OUT + i)*WW +: WW] = 8'sd31;
      wt_mat[(i*N_OUT + (i+1)%N_OUT)*WW +: WW] = 8'sd16;
      wt_mat[(i*N_OUT + (i+2)%N_OUT)*WW +: WW] = -8'sd16;
    end

    do_reset();

    // R2 R4 R5 R6: accumulation, equality boundary, ignored strobe-low spike
    for (int k = 0; k < 12; k++) begin
      apply(VEC[k][28], int'(VEC[k][27:24]), int'($signed(VEC[k][23:16])), 1'b0,
            VEC[k][15:0], "R2/R4/R5/R6 table");
    end

    // R1: reset clears potentials
    apply(1'b1, 7, 15, 1'b0, '0, "R4 below threshold");
    do_reset();
    apply(1'b1, 7, 10, 1'b0, '0, "R1 potential cleared");
    apply(1'b1, 7, 11, 1'b0, 16'h0080, "R1 accumulate after reset");

    // R8 R9: back-to-back spikes
    do_reset();
    @(negedge clk); spike_vld = 1'b1; spike_src = 4'd0; spike_wt = 8'sd25;
    @(negedge clk); spike_src = 4'd1;
    @(negedge clk); spike_vld = 1'b0; spike_wt = '0;
    chk(spike_out, 16'h0001, "R8 first of pair");
    @(negedge clk);
    chk(spike_out, 16'h0002, "R8 second of pair");
    @(negedge clk);
    chk(spike_out, 16'h0000, "R9 pulse ends");

    // R7: input-layer decay
    do_reset();
    apply(1'b1, 2, 16, 1'b0, '0, "R7 setup");
    apply(1'b0, 0, 0, 1'b1, '0, "R7 decay only");
    apply(1'b1, 2, 12, 1'b0, '0, "R7 input halved");
    apply(1'b1, 2, 1, 1'b0, 16'h0004, "R7 input fires after decay");

    // R7: output-layer decay
    do_reset();
    apply(1'b1, 8, 25, 1'b0, 16'h0100, "R7 out setup");
    apply(1'b0, 0, 0, 1'b1, '0, "R7 out decay");
    apply(1'b1, 8, 25, 1'b0, 16'h0100, "R7 output halved");

    // R7: decay and spike together, halve first
    do_reset();
    apply(1'b1, 12, 20, 1'b0, '0, "R7 same-cycle setup");
    apply(1'b1, 12, 11, 1'b1, 16'h1000, "R7 halve before add");

    // R3: upper saturation
    do_reset();
    set_thr_in(10, 511);
    for (int k = 0; k < 5; k++) apply(1'b1, 10, 127, 1'b0, '0, "R3 pump up");
    set_thr_in(10, 510);
    apply(1'b1, 10, 0, 1'b0, 16'h0400, "R3 clamp at max");
    set_thr_in(10, 20);

    // R3: lower saturation
    do_reset();
    set_thr_in(11, 0);
    for (int k = 0; k < 5; k++) apply(1'b1, 11, -128, 1'b0, '0, "R3 pump down");
    apply(1'b1, 11, 0, 1'b0, '0, "R3 clamp at min");
    set_thr_in(11, 20);

    // R6: per-neuron output threshold
    do_reset();
    set_thr_out(3, 40);
    apply(1'b1, 3, 25, 1'b0, '0, "R6 raised threshold holds");
    set_thr_out(3, 30);
    apply(1'b1, 3, 25, 1'b0, 16'h0018, "R6 accumulated pair fires");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule